// File: doc/BRIEF.md
# IR carrier modulating transmitter

This block plays back a stream of infrared mark and space durations. Software, or an upstream engine, writes 17-bit words into an eight-entry queue. Each word names a level (mark or space) and a 16-bit length. The block turns the queue into a timed output waveform. A programmable divider turns the reference clock into a tick. That tick paces both the pulse length and the carrier.

During a mark the output can carry a carrier. One carrier cycle lasts sixteen ticks, and a 4-bit code sets how many of those ticks are high. With modulation off, a mark is a steady active level. A polarity control decides whether the line reads 1 or 0 for a mark.

The block drives a service request so the feeder knows when to refill the queue. The request asserts either when the queue is down to half or when it is completely drained, selected by one control input. Clearing the enable stops everything at once and empties the queue.

Top module: `ir_tx_modulator`

## Requirements
- R1: A tick comes every div+1 clock cycles. A word with length field c holds its level for exactly (4*c+3) ticks, that is (4*c+3)*(div+1) cycles, counted from the first cycle busy is high for that word.
- R2: A word carries its level in bit 16 (1 = mark, 0 = space) and its length in bits 15:0. Words play in the order written, and one follows the previous with no gap cycle.
- R3: With mod_en high, a mark is a carrier whose phase counts ticks 0 to 15 and restarts at 0 at the start of every pulse. The carrier is active while phase <= duty, so it is active for duty+1 of every 16 ticks.
- R4: With mod_en low, a mark drives the active level steadily for its whole length.
- R5: With invert low, tx_out is 1 for an active mark and 0 otherwise. With invert high, tx_out is the complement, so the idle line is 1.
- R6: The queue holds 8 words. wr_ready is low when the queue is full or tx_en is low. A write offered while wr_ready is low is dropped.
- R7: While tx_en is high, svc_req reflects the queue fill. With req_on_empty low it is high when 4 or fewer words are queued. With req_on_empty high it is high only when none are queued. svc_req is low while tx_en is low.
- R8: busy is high while a pulse plays. When the last queued pulse ends, busy falls and tx_out returns to the space level in the next cycle.
- R9: When tx_en goes low, tx_out shows the space level in that same cycle. busy is low from the next cycle, and every queued word is discarded.
- R10: After reset, with tx_en low, busy, tx_out (invert low), wr_ready and svc_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable; low flushes the queue and forces space |
| mod_en | input | 1 | Put the carrier onto marks |
| invert | input | 1 | Output polarity: 1 means a mark reads 0 |
| req_on_empty | input | 1 | Service request threshold: 0 = half empty, 1 = empty |
| div | input | 16 | Tick divider; one tick = div+1 clocks |
| duty | input | 4 | Carrier high time code; active for duty+1 of 16 ticks |
| wr_valid | input | 1 | Write strobe for the queue |
| wr_data | input | 17 | Bit 16 level, bits 15:0 length code |
| wr_ready | output | 1 | Queue can take a word this cycle |
| tx_out | output | 1 | Modulated IR drive line |
| busy | output | 1 | A pulse is playing |
| svc_req | output | 1 | Queue wants refilling |

## Verification
The bench measures every pulse cycle by cycle against its own model. A length scaled wrongly, a divider off by one, or a gap cycle between words would show up as a mismatch in the segment where it happens. Carrier runs span several carrier periods with duty codes of 0, 3 and 15. This exposes a phase that fails to restart at a pulse boundary, or a compare that gives duty ticks instead of duty+1. The queue is driven to full while a long pulse plays, and a ninth write is then offered. A design that accepted that write would play an extra pulse, and the end-of-playback check would catch it. The bench also drops tx_en in the middle of a pulse and checks that the line shows space in that same cycle and that no queued word plays after re-enable.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

    // Playback sequencer state.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_PLAY = 1'b1
    } seq_state_e;

endpackage

// File: rtl/ir_tx_fifo.sv
module ir_tx_fifo #(
    parameter int W     = 17,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] fill,
    output logic             full,
    output logic             empty
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t q, d;
    logic  push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (q.cnt == CNT_W'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign head    = q.mem[q.rp];
    assign fill    = q.cnt;
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    always_comb begin
        d = q;
        if (flush) begin
            d.wp  = '0;
            d.rp  = '0;
            d.cnt = '0;
        end else begin
            if (push_ok) begin
                d.mem[q.wp] = push_data;
                d.wp        = step(q.wp);
            end
            if (pop_ok) begin
                d.rp = step(q.rp);
            end
            d.cnt = q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/ir_tx_tick.sv
module ir_tx_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tick_t;

    tick_t q, d;

    assign tick = run && (q.cnt == div);

    always_comb begin
        d = q;
        if (!run || restart || tick) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/ir_tx_carrier.sv
module ir_tx_carrier #(
    parameter int PHASES = 16,
    localparam int PH_W  = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            advance,
    input  logic [PH_W-1:0] duty,
    output logic            high
);

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } car_t;

    car_t q, d;

    assign high = (q.phase <= duty);

    always_comb begin
        d = q;
        if (restart) begin
            d.phase = '0;
        end else if (advance) begin
            d.phase = (q.phase == PH_W'(PHASES - 1)) ? '0 : q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/ir_tx_modulator.sv
module ir_tx_modulator
    import ir_tx_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DEPTH  = 8,
    parameter int DIV_W  = 16,
    parameter int PHASES = 16,
    localparam int WORD_W = CNT_W + 1,
    localparam int REM_W  = CNT_W + 2,
    localparam int PH_W   = $clog2(PHASES),
    localparam int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              mod_en,
    input  logic              invert,
    input  logic              req_on_empty,
    input  logic [DIV_W-1:0]  div,
    input  logic [PH_W-1:0]   duty,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              tx_out,
    output logic              busy,
    output logic              svc_req
);

    typedef struct packed {
        seq_state_e       st;
        logic             level;
        logic [REM_W-1:0] rem;
    } seq_t;

    seq_t q, d;

    logic [WORD_W-1:0] head;
    logic [FILL_W-1:0] fill;
    logic              full, empty;
    logic              tick, car_high;
    logic              pulse_end, pop, run, active;

    assign pulse_end = (q.st == SEQ_PLAY) && tick && (q.rem == '0);
    assign pop       = tx_en && !empty && ((q.st == SEQ_IDLE) || pulse_end);
    assign run       = tx_en && (q.st == SEQ_PLAY);

    ir_tx_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!tx_en),
        .push      (wr_valid && tx_en),
        .push_data (wr_data),
        .pop       (pop),
        .head      (head),
        .fill      (fill),
        .full      (full),
        .empty     (empty)
    );

    ir_tx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (pop),
        .div     (div),
        .tick    (tick)
    );

    ir_tx_carrier #(.PHASES(PHASES)) u_carrier (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (pop),
        .advance (tick),
        .duty    (duty),
        .high    (car_high)
    );

    // Pulse length in ticks is 4*c+3; the countdown starts one below so
    // the pulse ends on the tick seen with a zero remainder.
    always_comb begin
        d = q;
        if (!tx_en) begin
            d.st    = SEQ_IDLE;
            d.level = 1'b0;
            d.rem   = '0;
        end else if (pop) begin
            d.st    = SEQ_PLAY;
            d.level = head[CNT_W];
            d.rem   = {head[CNT_W-1:0], 2'b10};
        end else if (pulse_end) begin
            d.st    = SEQ_IDLE;
            d.level = 1'b0;
        end else if (run && tick) begin
            d.rem   = q.rem - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: SEQ_IDLE, level: 1'b0, rem: '0};
        end else begin
            q <= d;
        end
    end

    assign active   = run && q.level && (!mod_en || car_high);
    assign tx_out   = active ^ invert;
    assign busy     = (q.st == SEQ_PLAY);
    assign wr_ready = tx_en && !full;
    assign svc_req  = tx_en && (req_on_empty ? empty
                                             : (fill <= FILL_W'(DEPTH / 2)));

endmodule

// File: rtl/ir_tx_modulator_chk.sv
module ir_tx_modulator_chk #(
    parameter int DEPTH  = 8,
    parameter int FILL_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_en,
    input logic              invert,
    input logic              busy,
    input logic              tx_out,
    input logic              wr_ready,
    input logic              svc_req,
    input logic [FILL_W-1:0] fill
);

    p_space_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (tx_out == invert));

    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (fill == '0 && !busy));

    p_idle_space_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tx_out == invert));

    p_full_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == FILL_W'(DEPTH)) |-> !wr_ready);

    p_bounded_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_W'(DEPTH));

    p_svc_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !svc_req);

endmodule

bind ir_tx_modulator ir_tx_modulator_chk #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_chk (.*);

// File: tb/tb_ir_tx_modulator.sv
module tb_ir_tx_modulator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0, mod_en = 1'b0, invert = 1'b0, req_on_empty = 1'b0;
    logic [15:0] div = '0;
    logic [3:0]  duty = '0;
    logic        wr_valid = 1'b0;
    logic [16:0] wr_data = '0;
    logic        wr_ready, tx_out, busy, svc_req;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    typedef struct {
        logic lvl;
        int   len;
        logic md;
        logic inv;
        int   dv;
        int   dt;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;

    ir_tx_modulator dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .mod_en(mod_en),
        .invert(invert), .req_on_empty(req_on_empty), .div(div), .duty(duty),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .tx_out(tx_out), .busy(busy), .svc_req(svc_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: optionally records the expected pulse, then writes the word.
    task automatic send(input logic lvl, input int cnt, input bit track);
        item_t it;
        if (track) begin
            it.lvl = lvl; it.len = (4 * cnt + 3) * (int'(div) + 1);
            it.md = mod_en; it.inv = invert; it.dv = int'(div); it.dt = int'(duty);
            sb.push_back(it);
        end
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = {lvl, 16'(cnt)};
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while ((busy || sb.size() > 0) && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compares each pulse segment cycle by cycle (R1 R2 R3 R4 R5),
    // then the idle state after the last one (R8).
    initial begin
        forever begin
            @(negedge clk);
            if (busy && sb.size() > 0) begin
                item_t it;
                logic last_inv = 1'b0;
                while (sb.size() > 0) begin
                    bit bad = 0;
                    int bad_act = 0, bad_exp = 0;
                    it = sb.pop_front();
                    last_inv = it.inv;
                    for (int t = 0; t < it.len; t++) begin
                        logic mk, ex;
                        mk = it.lvl && (!it.md || (((t / (it.dv + 1)) % 16) <= it.dt));
                        ex = mk ^ it.inv;
                        if (tx_out !== ex && !bad) begin
                            bad = 1; bad_act = t; bad_exp = int'(ex);
                        end
                        @(negedge clk);
                    end
                    chk(!bad, "R1/R2 pulse segment (actual=first bad cycle)", bad_act, bad_exp);
                end
                chk(busy == 1'b0, "R8 busy after last pulse", int'(busy), 0);
                chk(tx_out == last_inv, "R8 space after last pulse", int'(tx_out), int'(last_inv));
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(busy == 0, "R10 busy", int'(busy), 0);
        chk(tx_out == 0, "R10 tx_out", int'(tx_out), 0);
        chk(wr_ready == 0, "R10 wr_ready", int'(wr_ready), 0);
        chk(svc_req == 0, "R10 svc_req", int'(svc_req), 0);

        tx_en = 1'b1;
        @(negedge clk);
        chk(svc_req == 1, "R7 empty half-threshold", int'(svc_req), 1);
        chk(wr_ready == 1, "R6 ready when empty", int'(wr_ready), 1);

        // R1 R2 R4: unmodulated sequence, div 2
        div = 16'd2;
        send(1'b1, 0, 1); send(1'b0, 1, 1); send(1'b1, 2, 1);
        drain();

        // R5: inverted polarity
        invert = 1'b1; div = 16'd1;
        @(negedge clk);
        chk(tx_out == 1, "R5 inverted idle", int'(tx_out), 1);
        send(1'b1, 1, 1); send(1'b0, 0, 1);
        drain();
        invert = 1'b0;

        // R3: carrier with several duty codes
        mod_en = 1'b1; div = 16'd0; duty = 4'd3;
        send(1'b1, 9, 1); send(1'b0, 1, 1); send(1'b1, 5, 1);
        drain();
        duty = 4'd15; send(1'b1, 4, 1); drain();
        duty = 4'd0;  send(1'b1, 8, 1); drain();
        div = 16'd2; duty = 4'd7; send(1'b1, 10, 1); drain();
        mod_en = 1'b0;

        // R6 R7: fill while a long pulse plays
        div = 16'd0; req_on_empty = 1'b0;
        send(1'b1, 200, 1);
        repeat (3) @(negedge clk);
        for (int k = 0; k < 4; k++) send(k[0], 0, 1);
        chk(svc_req == 1, "R7 four queued half-threshold", int'(svc_req), 1);
        send(1'b1, 1, 1);
        chk(svc_req == 0, "R7 five queued half-threshold", int'(svc_req), 0);
        req_on_empty = 1'b1;
        @(negedge clk);
        chk(svc_req == 0, "R7 five queued empty-threshold", int'(svc_req), 0);
        for (int k = 0; k < 3; k++) send(1'b0, 1, 1);
        chk(wr_ready == 0, "R6 full", int'(wr_ready), 0);
        send(1'b1, 3, 0);   // dropped: the monitor would see an extra pulse
        drain();
        chk(svc_req == 1, "R7 drained empty-threshold", int'(svc_req), 1);

        // R9: disable mid-pulse
        send(1'b1, 100, 0); send(1'b0, 5, 0);
        repeat (10) @(negedge clk);
        chk(tx_out == 1, "R2 mark playing", int'(tx_out), 1);
        tx_en = 1'b0;
        #1;
        chk(tx_out == 0, "R9 space same cycle", int'(tx_out), 0);
        @(negedge clk);
        chk(busy == 0, "R9 busy next cycle", int'(busy), 0);
        chk(svc_req == 0, "R7 svc off when disabled", int'(svc_req), 0);
        tx_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 0, "R9 queue flushed", int'(busy), 0);
        chk(tx_out == 0, "R9 stays space", int'(tx_out), 0);

        // R6: write while disabled is dropped
        tx_en = 1'b0;
        send(1'b1, 2, 0);
        tx_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 0, "R6 write while disabled dropped", int'(busy), 0);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule